// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock cycle. In that cycle it fetches a word from its own instruction store, reads two operands from a 32-entry register file, and computes a result in a combinational ALU. It then optionally accesses its own data store and writes the result back. The instruction set is deliberately narrow: five register-to-register operations (add, subtract, AND, OR, signed set-on-less-than), a word load, a word store and a conditional branch taken on register equality. Every other encoding executes as a no-op.

Both memories are arrays inside the block and are addressed by word, using address bits [31:2] reduced modulo their depth. A side-loading port fills either memory before or while the core runs. Two debug outputs show the current program counter and any one register, so that a test environment can observe progress without any bus interface.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC becomes 0 and all 32 registers become 0. Data memory and instruction memory keep their contents through reset.
- R2: Each cycle the core executes the word at instruction-memory index PC[IA_W+1:2]. The index wraps modulo IMEM_WORDS. Unless a branch is taken, the PC advances by exactly 4 and stays a multiple of 4.
- R3: Opcode 0 (bits [31:26]) selects the register format, with rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]. Funct 32 writes rs+rt to rd, funct 34 writes rs−rt, funct 36 writes rs AND rt, and funct 37 writes rs OR rt. Add and subtract wrap modulo 2^32.
- R4: Funct 42 under opcode 0 writes 1 to rd if rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 35 (load) forms the address R[rs] + sign-extended imm[15:0]. It writes data-memory word address[DA_W+1:2] into rt.
- R6: Opcode 43 (store) forms the same address and writes R[rt] into that data word. It writes no register.
- R7: With opcode 4 (branch), if R[rs] equals R[rt] the next PC is PC+4 + (sign-extended imm[15:0] shifted left by 2). Otherwise the next PC is PC+4.
- R8: Register 0 always reads as 0. Writes to it have no effect.
- R9: Any other opcode, and any funct outside {32,34,36,37,42} under opcode 0, changes no register and no memory word. The PC advances by 4.
- R10: `dbg_reg_data` shows register `dbg_reg_sel` combinationally, in the same cycle that the selector changes. `dbg_pc` shows the current PC.
- R11: When `load_en` is high at a rising edge, `load_data` is written to word `load_addr`. The target is data memory when `load_to_data` is 1 and instruction memory otherwise. In the same cycle, this write takes precedence over a store to the same data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of PC and registers |
| load_en | input | 1 | Side-load write strobe |
| load_to_data | input | 1 | Side-load target: 1 data memory, 0 instruction memory |
| load_addr | input | LD_W (6) | Side-load word index |
| load_data | input | 32 | Side-load word value |
| dbg_reg_sel | input | 5 | Register number shown on `dbg_reg_data` |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
A directed program with hand-computed results exercises each instruction once. It sets signed operands of opposite sign so that signed and unsigned compares give different results, forms a negative load offset, and stores a value that a later load reads back. It also writes to register 0, includes two kinds of invalid encoding, and places one untaken and one taken branch ahead of a self-loop. These cases separate sign handling, operand order and branch-target scaling errors. Random programs over random data memory contents then run against an instruction-level reference model, which the bench compares on every cycle through the PC and a rotating register readout. The random programs cover operand hazards between consecutive instructions, wrap-around of both memories and frequent taken branches.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RA_W = $clog2(NREG);

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    valid;
        logic    reg_we;
        logic    dst_is_rd;
        logic    use_imm;
        logic    mem_we;
        logic    mem_to_reg;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        case (opcode)
            OPC_RTYPE: begin
                ctrl.valid     = 1'b1;
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rd = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl = '0;
                endcase
            end
            OPC_LW: begin
                ctrl.valid      = 1'b1;
                ctrl.reg_we     = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.alu_op     = ALU_ADD;
            end
            OPC_SW: begin
                ctrl.valid   = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OPC_BEQ: begin
                ctrl.valid  = 1'b1;
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (y == '0);
    end

    always_comb begin
        // R4
        slt_bool_chk: assert (op != ALU_SLT || y[W-1:1] == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int N = 32,
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    input  logic [AW-1:0] raddr_c,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_c
);

    localparam int AW = $clog2(N);

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];
    logic [N-1:0] wsel;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign wsel[g] = we && (waddr == AW'(g));
        if (g == 0) begin : g_hardzero
            assign regs_d[g] = '0;
        end else begin : g_gpr
            assign regs_d[g] = rst ? '0 : (wsel[g] ? wdata : regs_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];
    assign rdata_c = regs_q[raddr_c];

    // R3
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        (we && waddr != '0) |=> regs_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IA_W = $clog2(IMEM_WORDS),
    localparam int DA_W = $clog2(DMEM_WORDS),
    localparam int LD_W = (IA_W > DA_W) ? IA_W : DA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_en,
    input  logic            load_to_data,
    input  logic [LD_W-1:0] load_addr,
    input  logic [31:0]     load_data,
    input  logic [4:0]      dbg_reg_sel,
    output logic [31:0]     dbg_reg_data,
    output logic [31:0]     dbg_pc
);

    core_state_t st_q, st_d;
    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] imem_d [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];
    logic [XLEN-1:0] dmem_d [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    logic [RA_W-1:0] rs_f, rt_f, rd_f, wr_sel;
    logic [XLEN-1:0] imm_ext, rs_val, rt_val, alu_b, alu_y, wb_val, ld_word;
    logic [XLEN-1:0] pc_plus4, br_tgt;
    logic [DA_W-1:0] d_idx;
    logic            zero, taken;
    ctrl_t           ctrl;

    assign instr   = imem_q[st_q.pc[IA_W+1:2]];
    assign rs_f    = instr[25:21];
    assign rt_f    = instr[20:16];
    assign rd_f    = instr[15:11];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    sc_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.N(NREG), .W(XLEN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (ctrl.reg_we && !rst),
        .waddr   (wr_sel),
        .wdata   (wb_val),
        .raddr_a (rs_f),
        .raddr_b (rt_f),
        .raddr_c (dbg_reg_sel),
        .rdata_a (rs_val),
        .rdata_b (rt_val),
        .rdata_c (dbg_reg_data)
    );

    assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (zero)
    );

    assign d_idx    = alu_y[DA_W+1:2];
    assign ld_word  = dmem_q[d_idx];
    assign wb_val   = ctrl.mem_to_reg ? ld_word : alu_y;
    assign wr_sel   = ctrl.dst_is_rd ? rd_f : rt_f;
    assign pc_plus4 = st_q.pc + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign taken    = ctrl.branch && zero;

    always_comb begin
        st_d   = st_q;
        imem_d = imem_q;
        dmem_d = dmem_q;
        if (rst) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = taken ? br_tgt : pc_plus4;
            if (ctrl.mem_we) begin
                dmem_d[d_idx] = rt_val;
            end
        end
        if (load_en) begin
            if (load_to_data) begin
                dmem_d[load_addr[DA_W-1:0]] = load_data;
            end else begin
                imem_d[load_addr[IA_W-1:0]] = load_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q   <= st_d;
        imem_q <= imem_d;
        dmem_q <= dmem_d;
    end

    assign dbg_pc = st_q.pc;

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], st_q.pc[XLEN-1:IA_W+2], st_q.pc[1:0],
                           alu_y[XLEN-1:DA_W+2], alu_y[1:0], load_addr};

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !taken |=> st_q.pc == $past(st_q.pc) + 32'd4);

    // R7
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        taken |=> st_q.pc == $past(st_q.pc) + 32'd4 + {$past(imm_ext[29:0]), 2'b00});

    // R2
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pc[1:0] == 2'b00);

    // R9
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl.valid |-> (!ctrl.reg_we && !ctrl.mem_we && !ctrl.branch));

    // R6
    store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_we |-> !ctrl.reg_we);

endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IW = 64;
    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        load_to_data = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [31:0] dbg_pc;

    always #4 clk = ~clk;

    sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) i_sc_core (
        .clk          (clk),
        .rst          (rst),
        .load_en      (load_en),
        .load_to_data (load_to_data),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc)
    );

    int total = 0;
    int bad = 0;
    int rot = 0;

    logic [31:0] ref_imem [IW];
    logic [31:0] ref_dmem [DW];
    logic [31:0] ref_rf   [32];
    logic [31:0] ref_pc;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    task automatic put(input bit to_d, input int idx, input logic [31:0] d);
        @(negedge clk);
        load_en      = 1'b1;
        load_to_data = to_d;
        load_addr    = 6'(idx);
        load_data    = d;
        if (to_d) ref_dmem[idx] = d;
        else      ref_imem[idx] = d;
    endtask

    task automatic put_end();
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        ref_pc = '0;
        for (int r = 0; r < 32; r++) ref_rf[r] = '0;
    endtask

    task automatic leave_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    // reference model of one instruction, derived from R2..R9
    function automatic bit iss_step();
        logic [31:0] ins, a, b, sx, addr, nxt, res;
        logic [5:0]  op, fn;
        int rs, rt, rd;
        bit br, wr;
        ins  = ref_imem[ref_pc[7:2]];
        op   = ins[31:26];
        fn   = ins[5:0];
        rs   = int'(ins[25:21]);
        rt   = int'(ins[20:16]);
        rd   = int'(ins[15:11]);
        a    = ref_rf[rs];
        b    = ref_rf[rt];
        sx   = {{16{ins[15]}}, ins[15:0]};
        addr = a + sx;
        nxt  = ref_pc + 32'd4;
        br   = 1'b0;
        wr   = 1'b1;
        res  = '0;
        case (op)
            6'd0: begin
                case (fn)
                    6'd32:   res = a + b;
                    6'd34:   res = a - b;
                    6'd36:   res = a & b;
                    6'd37:   res = a | b;
                    6'd42:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wr = 1'b0;
                endcase
                if (wr && rd != 0) ref_rf[rd] = res;
            end
            6'd35: if (rt != 0) ref_rf[rt] = ref_dmem[addr[7:2]];
            6'd43: ref_dmem[addr[7:2]] = b;
            6'd4: begin
                br = 1'b1;
                if (a == b) nxt = ref_pc + 32'd4 + {sx[29:0], 2'b00};
            end
            default: ;
        endcase
        ref_pc = nxt;
        return br;
    endfunction

    task automatic run(input int n);
        bit br;
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            br = iss_step();
            @(negedge clk);
            dbg_reg_sel = 5'(rot);
            #1;
            if (rot == 0) chk("R8", "x0 vs model", dbg_reg_data, ref_rf[0]);
            else          chk("R3", $sformatf("x%0d vs model", rot), dbg_reg_data, ref_rf[rot]);
            if (br) chk("R7", "pc after branch", dbg_pc, ref_pc);
            else    chk("R2", "pc step", dbg_pc, ref_pc);
            rot = (rot + 1) % 32;
        end
    endtask

    task automatic peek(input int r, input logic [31:0] exp, input string req, input string what);
        dbg_reg_sel = 5'(r);
        #1;
        chk(req, what, dbg_reg_data, exp);
    endtask

    function automatic logic [31:0] rand_instr();
        int k;
        logic [15:0] off;
        k = int'($urandom % 10);
        case (k)
            0: return enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), 32);
            1: return enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), 34);
            2: return enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 8), 36);
            3: return enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 32), 37);
            4: return enc_r(int'($urandom % 8), int'($urandom % 8), int'($urandom % 32), 42);
            5: begin
                off = 16'($urandom % 512) - 16'd256;
                return enc_i(35, int'($urandom % 8), int'($urandom % 32), off);
            end
            6: begin
                off = 16'($urandom % 512) - 16'd256;
                return enc_i(43, int'($urandom % 8), int'($urandom % 8), off);
            end
            7: begin
                off = 16'($urandom % 16) - 16'd8;
                return enc_i(4, int'($urandom % 4), int'($urandom % 4), off);
            end
            8: return {6'(8 + ($urandom % 8)), 26'($urandom)};
            default: return {6'd0, 20'($urandom), 6'($urandom % 32)};
        endcase
    endfunction

    initial begin
        void'($urandom(32'd9137));
        ref_pc = '0;
        for (int r = 0; r < 32; r++) ref_rf[r] = '0;
        for (int i = 0; i < IW; i++) ref_imem[i] = '0;
        for (int i = 0; i < DW; i++) ref_dmem[i] = '0;

        // directed program, loaded while reset is held (R11)
        put(0, 0,  enc_i(35, 0, 1, 16'd0));
        put(0, 1,  enc_i(35, 0, 2, 16'd4));
        put(0, 2,  enc_i(35, 0, 3, 16'd8));
        put(0, 3,  enc_i(35, 0, 4, 16'd12));
        put(0, 4,  enc_r(1, 2, 5, 32));
        put(0, 5,  enc_r(1, 2, 6, 34));
        put(0, 6,  enc_r(1, 2, 7, 36));
        put(0, 7,  enc_r(1, 2, 8, 37));
        put(0, 8,  enc_r(2, 1, 9, 42));
        put(0, 9,  enc_r(1, 2, 10, 42));
        put(0, 10, enc_r(3, 4, 11, 42));
        put(0, 11, enc_r(4, 1, 12, 32));
        put(0, 12, enc_i(43, 0, 6, 16'd16));
        put(0, 13, enc_i(35, 1, 13, 16'd11));
        put(0, 14, enc_i(35, 6, 14, 16'hFFFC));
        put(0, 15, enc_r(1, 1, 0, 32));
        put(0, 16, 32'hFC00_0000);
        put(0, 17, enc_r(2, 2, 1, 0));
        put(0, 18, enc_i(4, 1, 2, 16'd10));
        put(0, 19, enc_i(4, 5, 5, 16'd2));
        put(0, 20, enc_r(1, 1, 15, 32));
        put(0, 21, enc_r(1, 1, 15, 32));
        put(0, 22, enc_r(1, 1, 16, 32));
        put(0, 23, enc_i(4, 0, 0, 16'hFFFF));
        put(1, 0, 32'd5);
        put(1, 1, 32'hFFFF_FFFD);
        put(1, 2, 32'h8000_0000);
        put(1, 3, 32'h7FFF_FFFF);
        put_end();

        chk("R1", "pc in reset", dbg_pc, 32'd0);
        peek(7, 32'd0, "R1", "x7 in reset");

        leave_reset();
        run(40);

        peek(1,  32'd5,          "R5", "lw x1");
        peek(2,  32'hFFFF_FFFD,  "R5", "lw x2");
        peek(14, 32'hFFFF_FFFD,  "R5", "lw negative offset");
        peek(5,  32'd2,          "R3", "add");
        peek(6,  32'd8,          "R3", "sub");
        peek(7,  32'd5,          "R3", "and");
        peek(8,  32'hFFFF_FFFD,  "R3", "or");
        peek(12, 32'h8000_0004,  "R3", "add wraps");
        peek(9,  32'd1,          "R4", "slt neg<pos");
        peek(10, 32'd0,          "R4", "slt pos<neg");
        peek(11, 32'd1,          "R4", "slt min<max signed");
        peek(13, 32'd8,          "R6", "stored word read back");
        peek(6,  32'd8,          "R6", "store leaves rt");
        peek(0,  32'd0,          "R8", "x0 after write");
        peek(1,  32'd5,          "R9", "bad funct left x1");
        peek(15, 32'd0,          "R7", "skipped by taken branch");
        peek(16, 32'd10,         "R7", "branch target executed");
        chk("R11", "pc parked on loaded loop", dbg_pc, 32'd92);
        dbg_reg_sel = 5'd5;
        #1;
        chk("R10", "same-cycle read x5", dbg_reg_data, 32'd2);
        dbg_reg_sel = 5'd12;
        #1;
        chk("R10", "same-cycle read x12", dbg_reg_data, 32'h8000_0004);

        enter_reset();
        chk("R1", "pc after reset", dbg_pc, 32'd0);
        for (int r = 0; r < 32; r++) peek(r, 32'd0, "R1", $sformatf("x%0d cleared", r));

        for (int p = 0; p < 3; p++) begin
            enter_reset();
            for (int i = 0; i < IW; i++) put(0, i, rand_instr());
            for (int i = 0; i < DW; i++) put(1, i, $urandom);
            put_end();
            leave_reset();
            run(400);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule